// File: doc/BRIEF.md
# Interpolating Chip Timing Tracker

This block keeps a CDMA receiver locked to chip timing once coarse acquisition is done. At pilot-symbol rate it receives two correlation magnitudes, one taken slightly ahead of the current timing estimate and one slightly behind. Their difference is the timing error. A proportional-plus-integral filter turns that error into a phase increment for a 16-bit numerically controlled oscillator (NCO).

The NCO advances once for every accepted sample of the complex input stream, which arrives at four samples per chip. Each time its accumulator wraps, the block emits one on-time chip sample. That sample is a linear blend of the current input sample and the one before it. The blend weight comes from the top three accumulator bits, so the timing grid has steps of one eighth of a sample. The sampling clock itself is never adjusted.

The loop runs only while a tracking input is high. When that input drops, the timing state is frozen.

Top module: `ctr_timing_loop`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the following: the accumulator (so `phase` reads 0), the integrator, `out_stb`, `out_i` and `out_q`. The phase increment is set to the nominal value `NOM_STEP` (16384 by default, giving one output per four samples).
- R2: At each edge where `sym_stb` and `track_en` are both high, the block forms the error e = `early_mag` − `late_mag` (both unsigned). The integrator I becomes I + e. The phase increment becomes NOM_STEP + (e >>> KP_SH) + (I_new >>> KI_SH), using arithmetic shifts. The new increment applies from the next accepted sample onward. At any other edge the increment is unchanged.
- R3: The phase increment is clamped to the range 1 to 65535 inclusive.
- R4: At each edge where `smp_stb` and `track_en` are both high, `phase` becomes (`phase` + increment) mod 65536. At all other edges `phase` holds its value.
- R5: `out_stb` is high for exactly the one cycle after an edge at which R4's addition carried out of bit 15. It is low in every other cycle.
- R6: The sample delay updates on every `smp_stb`, enabled or not. With x[n] as the current sample, x[n−1] as the previous one, and f as bits [15:13] of the wrapped accumulator, the output is x[n] + floor(f·(x[n−1] − x[n])/8). The same rule applies to I and Q. The outputs hold their values between strobes.
- R7: While `track_en` is low, the following are held: the integrator, the phase increment, and `phase`. `sym_stb` is ignored and `out_stb` stays low.
- R8: With no symbol updates after reset and tracking enabled, `out_stb` rises on every fourth accepted sample: the 4th, the 8th, and so on.
- R9: When `sym_stb` and `smp_stb` coincide, the accumulator in that cycle advances by the old increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_en | input | 1 | Tracking enable; the loop is frozen when low |
| sym_stb | input | 1 | Pilot-symbol strobe qualifying the magnitudes |
| early_mag | input | MAG_W | Early correlation magnitude, unsigned |
| late_mag | input | MAG_W | Late correlation magnitude, unsigned |
| smp_stb | input | 1 | Input sample strobe (4x chip rate) |
| smp_i | input | SMP_W | In-phase input sample, signed |
| smp_q | input | SMP_W | Quadrature input sample, signed |
| out_stb | output | 1 | On-time output strobe |
| out_i | output | SMP_W | Interpolated in-phase chip sample |
| out_q | output | SMP_W | Interpolated quadrature chip sample |
| phase | output | 16 | Current NCO accumulator |

## Verification
Some properties are checked by assertions on every cycle:
- the increment stays unchanged without a symbol update;
- the integrator and accumulator freeze while tracking is off;
- the increment never reaches zero;
- an output strobe never appears without an enabled sample whose addition wrapped.

Other properties only the bench's scenarios can show:
- that the increment equals the filter formula, including both clamp limits;
- that the interpolated values have the correct sign and rounding;
- that the nominal cadence is one output per four samples;
- that the old increment is used when a symbol update coincides with a sample.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int ACC_W  = 16;
    localparam int FRAC_W = 3;

    typedef struct packed {
        logic              wrap;
        logic [FRAC_W-1:0] frac;
    } nco_evt_t;

endpackage

// File: rtl/ctr_err_det.sv
module ctr_err_det #(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W-1:0]  early_mag,
    input  logic [MAG_W-1:0]  late_mag,
    output logic signed [MAG_W:0] err_o
);

    always_comb begin
        err_o = $signed({1'b0, early_mag}) - $signed({1'b0, late_mag});
    end

endmodule

// File: rtl/ctr_loop_filt.sv
module ctr_loop_filt
    import ctr_pkg::*;
#(
    parameter int MAG_W    = 16,
    parameter int INT_W    = 24,
    parameter int KP_SH    = 0,
    parameter int KI_SH    = 4,
    parameter int NOM_STEP = 16384
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  upd,
    input  logic signed [MAG_W:0] err_i,
    output logic [ACC_W-1:0]      step_o
);

    localparam int SW = INT_W + 2;
    localparam logic signed [SW-1:0] S_MIN = SW'(1);
    localparam logic signed [SW-1:0] S_MAX = SW'((1 << ACC_W) - 1);
    localparam logic signed [SW-1:0] S_NOM = SW'(NOM_STEP);

    logic signed [INT_W-1:0] integ;
    logic signed [SW-1:0]    e_x, i_n, ofs, sum;
    logic [ACC_W-1:0]        step_n;

    always_comb begin
        e_x = SW'(err_i);
        i_n = SW'(integ) + e_x;
        ofs = (e_x >>> KP_SH) + (i_n >>> KI_SH);
        sum = S_NOM + ofs;
        if (sum < S_MIN)
            step_n = ACC_W'(1);
        else if (sum > S_MAX)
            step_n = {ACC_W{1'b1}};
        else
            step_n = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ  <= '0;
            step_o <= ACC_W'(NOM_STEP);
        end else if (en && upd) begin
            integ  <= i_n[INT_W-1:0];
            step_o <= step_n;
        end
    end

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(en && upd) |=> $stable(step_o)); // R2

    AST_INTEG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(integ)); // R7

endmodule

// File: rtl/ctr_nco.sv
module ctr_nco
    import ctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             adv,
    input  logic [ACC_W-1:0] step_i,
    output nco_evt_t         evt_o,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W:0] nxt;

    always_comb begin
        nxt        = {1'b0, acc_o} + {1'b0, step_i};
        evt_o.wrap = nxt[ACC_W];
        evt_o.frac = nxt[ACC_W-1 -: FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_o <= '0;
        else if (en && adv)
            acc_o <= nxt[ACC_W-1:0];
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(en && adv) |=> $stable(acc_o)); // R4

    AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        step_i != '0); // R3

endmodule

// File: rtl/ctr_interp.sv
module ctr_interp
    import ctr_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] smp_in [2],
    input  nco_evt_t                evt_i,
    output logic                    out_stb,
    output logic signed [SMP_W-1:0] smp_out [2]
);

    localparam int PW = SMP_W + FRAC_W + 2;

    logic fire;
    assign fire = en && smp_stb && evt_i.wrap;

    always_ff @(posedge clk) begin
        if (rst)
            out_stb <= 1'b0;
        else
            out_stb <= fire;
    end

    for (genvar k = 0; k < 2; k++) begin : g_lane
        logic signed [SMP_W-1:0] prev;
        logic signed [SMP_W:0]   diff;
        logic signed [PW-1:0]    dx, fx, prod, blend;

        always_comb begin
            diff  = $signed({prev[SMP_W-1], prev}) - $signed({smp_in[k][SMP_W-1], smp_in[k]});
            dx    = PW'(diff);
            fx    = $signed(PW'({1'b0, evt_i.frac}));
            prod  = dx * fx;
            blend = PW'(smp_in[k]) + (prod >>> FRAC_W);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prev       <= '0;
                smp_out[k] <= '0;
            end else begin
                if (smp_stb)
                    prev <= smp_in[k];
                if (fire)
                    smp_out[k] <= blend[SMP_W-1:0];
            end
        end
    end

    AST_STB_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(en && smp_stb && evt_i.wrap) |=> !out_stb); // R5

endmodule

// File: rtl/ctr_timing_loop.sv
module ctr_timing_loop
    import ctr_pkg::*;
#(
    parameter int MAG_W    = 16,
    parameter int SMP_W    = 12,
    parameter int INT_W    = 24,
    parameter int KP_SH    = 0,
    parameter int KI_SH    = 4,
    parameter int NOM_STEP = 16384
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    track_en,
    input  logic                    sym_stb,
    input  logic [MAG_W-1:0]        early_mag,
    input  logic [MAG_W-1:0]        late_mag,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    output logic                    out_stb,
    output logic signed [SMP_W-1:0] out_i,
    output logic signed [SMP_W-1:0] out_q,
    output logic [ACC_W-1:0]        phase
);

    logic signed [MAG_W:0]   err;
    logic [ACC_W-1:0]        step;
    nco_evt_t                evt;
    logic signed [SMP_W-1:0] lanes_in  [2];
    logic signed [SMP_W-1:0] lanes_out [2];

    assign lanes_in[0] = smp_i;
    assign lanes_in[1] = smp_q;
    assign out_i       = lanes_out[0];
    assign out_q       = lanes_out[1];

    ctr_err_det #(.MAG_W(MAG_W)) u_err (
        .early_mag (early_mag),
        .late_mag  (late_mag),
        .err_o     (err)
    );

    ctr_loop_filt #(
        .MAG_W(MAG_W), .INT_W(INT_W), .KP_SH(KP_SH),
        .KI_SH(KI_SH), .NOM_STEP(NOM_STEP)
    ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .en     (track_en),
        .upd    (sym_stb),
        .err_i  (err),
        .step_o (step)
    );

    ctr_nco u_nco (
        .clk    (clk),
        .rst    (rst),
        .en     (track_en),
        .adv    (smp_stb),
        .step_i (step),
        .evt_o  (evt),
        .acc_o  (phase)
    );

    ctr_interp #(.SMP_W(SMP_W)) u_interp (
        .clk     (clk),
        .rst     (rst),
        .en      (track_en),
        .smp_stb (smp_stb),
        .smp_in  (lanes_in),
        .evt_i   (evt),
        .out_stb (out_stb),
        .smp_out (lanes_out)
    );

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !track_en |=> !out_stb); // R7

endmodule

// File: tb/tb_ctr_timing_loop.sv
module tb_ctr_timing_loop;

    localparam int MAG_W = 16;
    localparam int SMP_W = 12;
    localparam int KP    = 0;
    localparam int KI    = 4;
    localparam int NOM   = 16384;

    logic clk = 1'b0;
    logic rst;
    logic track_en, sym_stb, smp_stb;
    logic [MAG_W-1:0] early_mag, late_mag;
    logic signed [SMP_W-1:0] smp_i, smp_q, out_i, out_q;
    logic out_stb;
    logic [15:0] phase;

    int checks = 0;
    int errors = 0;

    longint m_int, m_step, m_acc;
    int m_pi, m_pq, m_oi, m_oq;
    bit m_ov;

    ctr_timing_loop #(.MAG_W(MAG_W), .SMP_W(SMP_W), .KP_SH(KP), .KI_SH(KI), .NOM_STEP(NOM)) dut (
        .clk(clk), .rst(rst), .track_en(track_en), .sym_stb(sym_stb),
        .early_mag(early_mag), .late_mag(late_mag), .smp_stb(smp_stb),
        .smp_i(smp_i), .smp_q(smp_q), .out_stb(out_stb), .out_i(out_i),
        .out_q(out_q), .phase(phase)
    );

    always #10 clk = ~clk;

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lerp(int cur, int prv, int f);
        return cur + ((f * (prv - cur)) >>> 3);
    endfunction

    function automatic void model_reset();
        m_int = 0; m_step = NOM; m_acc = 0;
        m_pi = 0; m_pq = 0; m_oi = 0; m_oq = 0; m_ov = 0;
    endfunction

    function automatic void model_edge(bit en, bit sv, int e, int l, bit mv, int si, int sq);
        longint nx, en_i, sum;
        int f;
        m_ov = 0;
        if (mv) begin
            if (en) begin
                nx    = m_acc + m_step;
                m_acc = nx % 65536;
                f     = int'((m_acc >> 13) & 7);
                if (nx >= 65536) begin
                    m_ov = 1;
                    m_oi = lerp(si, m_pi, f);
                    m_oq = lerp(sq, m_pq, f);
                end
            end
            m_pi = si; m_pq = sq;
        end
        if (en && sv) begin
            en_i  = m_int + longint'(e - l);
            sum   = NOM + (longint'(e - l) >>> KP) + (en_i >>> KI);
            m_int = en_i;
            m_step = (sum < 1) ? 1 : (sum > 65535) ? 65535 : sum;
        end
    endfunction

    task automatic cyc(bit en, bit sv, int e, int l, bit mv, int si, int sq);
        track_en = en; sym_stb = sv; early_mag = MAG_W'(e); late_mag = MAG_W'(l);
        smp_stb = mv; smp_i = SMP_W'(si); smp_q = SMP_W'(sq);
        @(posedge clk);
        model_edge(en, sv, e, l, mv, si, sq);
        @(negedge clk);
        chk(phase == 16'(m_acc), "R4 phase", phase, m_acc);
        chk(out_stb == m_ov, "R5 strobe", out_stb, m_ov);
        if (m_ov) begin
            chk(int'(out_i) == m_oi, "R6 out_i", out_i, m_oi);
            chk(int'(out_q) == m_oq, "R6 out_q", out_q, m_oq);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; track_en = 0; sym_stb = 0; smp_stb = 0;
        early_mag = 0; late_mag = 0; smp_i = 0; smp_q = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk(phase == 0, "R1 phase", phase, 0);
        chk(out_stb == 0, "R1 strobe", out_stb, 0);
        chk(out_i == 0 && out_q == 0, "R1 outputs", out_i, 0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd4242));
        do_reset();

        // R8: nominal cadence, strobe on every 4th sample
        cnt = 0;
        for (int n = 1; n <= 40; n++) begin
            cyc(1, 0, 0, 0, 1, n * 37 - 700, 500 - n * 11);
            if (out_stb) cnt++;
            chk(out_stb == ((n % 4) == 0), "R8 cadence", out_stb, (n % 4) == 0);
        end
        chk(cnt == 10, "R8 count", cnt, 10);

        // R6: known fraction, step 16384+6000 -> wrap residue sets f
        do_reset();
        cyc(1, 1, 6000, 0, 0, 0, 0);   // step = 16384+6000+375 = 22759
        chk(phase == 0, "R9 no sample yet", phase, 0);
        cyc(1, 0, 0, 0, 1, 100, -100);
        chk(phase == 16'd22759, "R2 increment", phase, 22759);
        cyc(1, 0, 0, 0, 1, 200, -200);
        cyc(1, 0, 0, 0, 1, 1000, -1000); // 68277 -> wrap, acc 2741, f 0
        chk(out_stb == 1 && out_i == 1000 && out_q == -1000, "R6 f zero", out_i, 1000);
        for (int n = 0; n < 3; n++) cyc(1, 0, 0, 0, 1, -800 + n, 640 - n);

        // R3: upper and lower clamp
        do_reset();
        cyc(1, 1, 65535, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 5, 5);
        chk(phase == 16'hFFFF, "R3 upper clamp", phase, 65535);
        cyc(1, 0, 0, 0, 1, 5, 5);
        chk(phase == 16'hFFFE && out_stb == 1, "R3 wrap at max", phase, 65534);
        cyc(1, 1, 0, 65535, 0, 0, 0);   // integ 0 -> sum below 1
        cyc(1, 0, 0, 0, 1, 5, 5);
        chk(phase == 16'hFFFF, "R3 lower clamp", phase, 65535);

        // R9: coincident symbol and sample use old step
        do_reset();
        cyc(1, 1, 3000, 0, 1, 10, 10);
        chk(phase == 16'(NOM), "R9 old step", phase, NOM);

        // R7: disabled loop ignores symbols and holds phase
        cyc(0, 1, 60000, 0, 1, 30, 30);
        chk(phase == 16'(NOM) && out_stb == 0, "R7 hold", phase, NOM);
        for (int n = 0; n < 6; n++) cyc(0, 1, 0, 50000, 1, n, -n);
        chk(phase == 16'(NOM), "R7 still held", phase, NOM);
        cyc(1, 0, 0, 0, 1, 7, 7);
        chk(phase == 16'(2 * NOM + 3000 + 187), "R7 step untouched by ignored symbols", phase, 2 * NOM + 3187);

        // Random mix
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int base, e, l, si, sq;
            bit en, sv, mv;
            base = int'($urandom_range(60000, 1000));
            e  = base + int'($urandom_range(400)) - 200;
            l  = base + int'($urandom_range(400)) - 200;
            en = ($urandom_range(9) != 0);
            sv = ($urandom_range(15) == 0);
            mv = ($urandom_range(3) != 0);
            si = int'($urandom_range(4095)) - 2048;
            sq = int'($urandom_range(4095)) - 2048;
            cyc(en, sv, e, l, mv, si, sq);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule